// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Condition Flags

This block is the purely combinational datapath of a small eight-bit processor core. It takes two operands, a carry input, an auxiliary-carry input and a five-bit operation code. From these it forms an eight-bit result, four condition flags and a skip decision. The flags are carry, auxiliary (nibble) carry, zero and overflow. The skip decision is used by the test-and-skip operations.

The block does not store flags. It drives a four-bit update mask next to the flag values, so the status register outside the block latches only the flags that the current operation affects. The flag positions in the mask match the bit order of that status register. Any flag that the current operation does not affect is driven low, so the outputs never carry stale or undefined values. The block contains no instruction decode, register file, program counter or storage.

Top module: `alu8_core`

## Requirements
- R1: Add (code 0) gives res = a+b, and add-with-carry (code 1) gives res = a+b+c_i. Carry is the carry out of bit 7 and auxiliary carry is the carry out of bit 3.
- R2: Subtract (code 2) gives res = a-b, and subtract-with-borrow (code 3) gives res = a-b-(1-c_i). Carry is 1 when no borrow leaves bit 7. Auxiliary carry is 1 when the low nibble needs no borrow from the high nibble.
- R3: For codes 0 to 3, overflow is 1 exactly when the carry into bit 7 differs from the carry out of bit 7. This is the same as a two's-complement result out of range.
- R4: Whenever the zero flag is updated, it is 1 exactly when res is 0x00.
- R5: upd_o marks the affected flags, with bit 0 for carry, bit 1 for auxiliary carry, bit 2 for zero and bit 3 for overflow. Codes 0 to 3 give 1111. Codes 5 to 8, 13 and 14 give 0100. Codes 4, 11 and 12 give 0001. All other codes give 0000.
- R6: Each flag output whose upd_o bit is 0 is driven 0.
- R7: Codes 5, 6 and 7 give a AND b, a OR b and a XOR b. Code 8 gives the bitwise complement of a.
- R8: Code 9 rotates a left by one bit within the eight bits, and code 10 rotates it right. Carry is unaffected.
- R9: Code 11 shifts a left with c_i entering bit 0, and carry takes the old bit 7. Code 12 shifts a right with c_i entering bit 7, and carry takes the old bit 0.
- R10: Code 13 gives a+1 and code 14 gives a-1, both wrapping modulo 256.
- R11: Decimal adjust (code 4) first adds 0x06 when the low nibble of a is above 9 or ac_i is 1. It then adds 0x60 when that value exceeds 0x99 or c_i is 1. Carry is 1 exactly when the 0x60 step is taken.
- R12: Skip operations update no flags. Code 15 (res = a) skips when a is zero, and code 16 (res = a) skips when a is nonzero. Code 17 (res = a+1) and code 18 (res = a-1) skip when res is zero. All other codes have skip_o = 0.
- R13: Undefined codes 19 to 31 give res = 0, upd_o = 0000 and skip_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Carry flag input |
| ac_i | input | 1 | Auxiliary carry flag input |
| res_o | output | 8 | Result |
| c_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary carry flag |
| z_o | output | 1 | Zero flag |
| ov_o | output | 1 | Overflow flag |
| upd_o | output | 4 | Flag update mask {ov, z, ac, c} |
| skip_o | output | 1 | Skip decision |

## Verification
The immediate assertions in the checker assume that every input is a known two-state value. They also assume that the inputs have settled, because the checker re-evaluates whenever the combinational outputs change. The bench changes the operands and the operation code only just after a rising clock edge, and it reads the outputs at the falling edge. As a result, every value the bench compares is a settled response to one stable input vector.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;
    localparam int FW  = 4;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBC = 5'd3,
        OP_DAA = 5'd4,
        OP_AND = 5'd5,
        OP_OR  = 5'd6,
        OP_XOR = 5'd7,
        OP_CPL = 5'd8,
        OP_RL  = 5'd9,
        OP_RR  = 5'd10,
        OP_RLC = 5'd11,
        OP_RRC = 5'd12,
        OP_INC = 5'd13,
        OP_DEC = 5'd14,
        OP_SZ  = 5'd15,
        OP_SNZ = 5'd16,
        OP_SIZ = 5'd17,
        OP_SDZ = 5'd18
    } op_e;

    // bit order matches the status register: [0]=c [1]=ac [2]=z [3]=ov
    typedef struct packed {
        logic ov;
        logic z;
        logic ac;
        logic c;
    } flags_t;

    typedef struct packed {
        word_t  res;
        flags_t flg;
        flags_t upd;
        logic   skip;
    } alu_out_t;

    localparam flags_t UPD_NONE = '{ov: 1'b0, z: 1'b0, ac: 1'b0, c: 1'b0};
    localparam flags_t UPD_ALL  = '{ov: 1'b1, z: 1'b1, ac: 1'b1, c: 1'b1};
    localparam flags_t UPD_Z    = '{ov: 1'b0, z: 1'b1, ac: 1'b0, c: 1'b0};
    localparam flags_t UPD_C    = '{ov: 1'b0, z: 1'b0, ac: 1'b0, c: 1'b1};

    localparam word_t BCD_LO_FIX = word_t'(8'h06);
    localparam word_t BCD_HI_FIX = word_t'(8'h60);
    localparam logic [NW-1:0] BCD_DIGIT_MAX = NW'(9);
    localparam logic [DW:0]   BCD_BYTE_MAX  = (DW+1)'(9'h099);

    function automatic logic word_is_zero(input word_t w);
        return (w == '0);
    endfunction

    function automatic logic op_is_arith(input op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBC);
    endfunction

    function automatic logic op_is_sub(input op_e op);
        return (op == OP_SUB) || (op == OP_SBC);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  word_t  a_i,
    input  word_t  b_i,
    input  logic   sub_i,
    input  logic   cin_i,
    output word_t  sum_o,
    output flags_t flg_o
);
    word_t            b_eff;
    logic [DW:0]      full;
    logic [DW-1:0]    below_top;
    logic [NW:0]      nib;
    logic             c_into_top;

    // subtraction is a + ~b + cin, so carry out means "no borrow"
    assign b_eff = sub_i ? ~b_i : b_i;

    assign full      = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_i};
    assign below_top = {1'b0, a_i[DW-2:0]} + {1'b0, b_eff[DW-2:0]} + {{(DW-1){1'b0}}, cin_i};
    assign nib       = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, cin_i};

    assign c_into_top = below_top[DW-1];
    assign sum_o      = full[DW-1:0];

    always_comb begin
        flg_o.c  = full[DW];
        flg_o.ac = nib[NW];
        flg_o.ov = c_into_top ^ full[DW];
        flg_o.z  = word_is_zero(full[DW-1:0]);
    end

endmodule

// File: rtl/alu8_daa.sv
module alu8_daa
    import alu8_pkg::*;
(
    input  word_t a_i,
    input  logic  c_i,
    input  logic  ac_i,
    output word_t res_o,
    output logic  c_o
);
    logic        lo_fix;
    logic        hi_fix;
    logic [DW:0] step1;
    logic [DW:0] step2;

    assign lo_fix = (a_i[NW-1:0] > BCD_DIGIT_MAX) || ac_i;
    assign step1  = {1'b0, a_i} + (lo_fix ? {1'b0, BCD_LO_FIX} : '0);
    assign hi_fix = (step1 > BCD_BYTE_MAX) || c_i;
    assign step2  = step1 + (hi_fix ? {1'b0, BCD_HI_FIX} : '0);

    assign res_o = step2[DW-1:0];
    assign c_o   = hi_fix;

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
(
    input  op_e   op_i,
    input  word_t a_i,
    input  word_t b_i,
    input  logic  c_i,
    output word_t res_o,
    output logic  c_o
);
    always_comb begin
        res_o = '0;
        c_o   = 1'b0;
        unique case (op_i)
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_CPL: res_o = ~a_i;
            OP_RL:  res_o = {a_i[DW-2:0], a_i[DW-1]};
            OP_RR:  res_o = {a_i[0], a_i[DW-1:1]};
            OP_RLC: begin
                res_o = {a_i[DW-2:0], c_i};
                c_o   = a_i[DW-1];
            end
            OP_RRC: begin
                res_o = {c_i, a_i[DW-1:1]};
                c_o   = a_i[0];
            end
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu8_step.sv
module alu8_step
    import alu8_pkg::*;
(
    input  op_e   op_i,
    input  word_t a_i,
    output word_t res_o,
    output logic  skip_o
);
    word_t up;
    word_t down;

    assign up   = a_i + word_t'(1);
    assign down = a_i - word_t'(1);

    always_comb begin
        res_o  = '0;
        skip_o = 1'b0;
        unique case (op_i)
            OP_INC: res_o = up;
            OP_DEC: res_o = down;
            OP_SZ: begin
                res_o  = a_i;
                skip_o = word_is_zero(a_i);
            end
            OP_SNZ: begin
                res_o  = a_i;
                skip_o = !word_is_zero(a_i);
            end
            OP_SIZ: begin
                res_o  = up;
                skip_o = word_is_zero(up);
            end
            OP_SDZ: begin
                res_o  = down;
                skip_o = word_is_zero(down);
            end
            default: begin
                res_o  = '0;
                skip_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    input  logic           c_i,
    input  logic           ac_i,
    output logic [DW-1:0]  res_o,
    output logic           c_o,
    output logic           ac_o,
    output logic           z_o,
    output logic           ov_o,
    output logic [FW-1:0]  upd_o,
    output logic           skip_o
);
    op_e      op;
    logic     as_sub;
    logic     as_cin;
    word_t    as_sum;
    flags_t   as_flg;
    word_t    daa_res;
    logic     daa_c;
    word_t    bit_res;
    logic     bit_c;
    word_t    stp_res;
    logic     stp_skip;
    alu_out_t sel;
    logic [FW-1:0] raw_flags;
    logic [FW-1:0] shown_flags;

    assign op = op_e'(op_i);

    // carry-in choice: plain ops fix it, the chained ops take c_i
    always_comb begin
        as_sub = op_is_sub(op);
        unique case (op)
            OP_ADD:  as_cin = 1'b0;
            OP_SUB:  as_cin = 1'b1;
            default: as_cin = c_i;
        endcase
    end

    alu8_addsub u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (as_sub),
        .cin_i (as_cin),
        .sum_o (as_sum),
        .flg_o (as_flg)
    );

    alu8_daa u_daa (
        .a_i   (a_i),
        .c_i   (c_i),
        .ac_i  (ac_i),
        .res_o (daa_res),
        .c_o   (daa_c)
    );

    alu8_bitops u_bitops (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .c_i   (c_i),
        .res_o (bit_res),
        .c_o   (bit_c)
    );

    alu8_step u_step (
        .op_i   (op),
        .a_i    (a_i),
        .res_o  (stp_res),
        .skip_o (stp_skip)
    );

    always_comb begin
        sel = '0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                sel.res = as_sum;
                sel.flg = as_flg;
                sel.upd = UPD_ALL;
            end
            OP_DAA: begin
                sel.res   = daa_res;
                sel.flg   = UPD_NONE;
                sel.flg.c = daa_c;
                sel.upd   = UPD_C;
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL: begin
                sel.res   = bit_res;
                sel.flg   = UPD_NONE;
                sel.flg.z = word_is_zero(bit_res);
                sel.upd   = UPD_Z;
            end
            OP_RL, OP_RR: begin
                sel.res = bit_res;
                sel.upd = UPD_NONE;
            end
            OP_RLC, OP_RRC: begin
                sel.res   = bit_res;
                sel.flg   = UPD_NONE;
                sel.flg.c = bit_c;
                sel.upd   = UPD_C;
            end
            OP_INC, OP_DEC: begin
                sel.res   = stp_res;
                sel.flg   = UPD_NONE;
                sel.flg.z = word_is_zero(stp_res);
                sel.upd   = UPD_Z;
            end
            OP_SZ, OP_SNZ, OP_SIZ, OP_SDZ: begin
                sel.res  = stp_res;
                sel.upd  = UPD_NONE;
                sel.skip = stp_skip;
            end
            default: sel = '0;
        endcase
    end

    // unaffected flags are forced low, one gate per flag
    assign raw_flags = sel.flg;
    for (genvar k = 0; k < FW; k++) begin : g_flag_gate
        assign shown_flags[k] = raw_flags[k] & sel.upd[k];
    end

    assign res_o  = sel.res;
    assign c_o    = shown_flags[0];
    assign ac_o   = shown_flags[1];
    assign z_o    = shown_flags[2];
    assign ov_o   = shown_flags[3];
    assign upd_o  = sel.upd;
    assign skip_o = sel.skip;

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
(
    input logic [OPW-1:0] op_i,
    input logic [DW-1:0]  a_i,
    input logic [DW-1:0]  b_i,
    input logic [DW-1:0]  res_o,
    input logic           c_o,
    input logic           ac_o,
    input logic           z_o,
    input logic           ov_o,
    input logic [FW-1:0]  upd_o,
    input logic           skip_o
);
    always_comb begin
        if (!$isunknown({op_i, a_i, b_i, res_o, upd_o, c_o, ac_o, z_o, ov_o, skip_o})) begin
            if (op_i == OP_ADD)
                assert_add_ovf_R3: assert (ov_o == ((a_i[DW-1] == b_i[DW-1]) && (res_o[DW-1] != a_i[DW-1])));
            if (op_i == OP_SUB)
                assert_sub_carry_R2: assert (c_o == (a_i >= b_i));
            if (upd_o[2])
                assert_zero_flag_R4: assert (z_o == (res_o == '0));
            if (op_i <= OP_SBC)
                assert_arith_mask_R5: assert (upd_o == 4'b1111);
            assert_hidden_flags_R6: assert ((~upd_o & {ov_o, z_o, ac_o, c_o}) == '0);
            if (op_i == OP_RL)
                assert_rotate_left_R8: assert ({res_o[0], res_o[DW-1:1]} == a_i && upd_o == '0);
            if (skip_o)
                assert_skip_source_R12: assert (op_i >= OP_SZ && op_i <= OP_SDZ && upd_o == '0);
            if (op_i > OP_SDZ)
                assert_undef_quiet_R13: assert (res_o == '0 && upd_o == '0 && !skip_o);
        end
    end
endmodule

bind alu8_core alu8_chk u_chk (
    .op_i   (op_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_o  (res_o),
    .c_o    (c_o),
    .ac_o   (ac_o),
    .z_o    (z_o),
    .ov_o   (ov_o),
    .upd_o  (upd_o),
    .skip_o (skip_o)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op  = 5'd31;
    logic [7:0] a   = '0;
    logic [7:0] b   = '0;
    logic       ci  = 1'b0;
    logic       aci = 1'b0;
    logic [7:0] res;
    logic       co, aco, zo, ovo, skp;
    logic [3:0] upd;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    alu8_core u_dut (
        .op_i(op), .a_i(a), .b_i(b), .c_i(ci), .ac_i(aci),
        .res_o(res), .c_o(co), .ac_o(aco), .z_o(zo), .ov_o(ovo),
        .upd_o(upd), .skip_o(skp)
    );

    // expected vector {res[7:0], ov, z, ac, c, upd[3:0], skip}
    function automatic logic [16:0] model(input int o, input int x, input int y,
                                          input int c, input int ac);
        int r = 0; int fc = 0; int fac = 0; int fz = 0; int fov = 0;
        int um = 0; int sk = 0; int sx; int sy; int sv; int bw; int t; int hi;
        sx = (x > 127) ? x - 256 : x;
        sy = (y > 127) ? y - 256 : y;
        case (o)
            0, 1: begin
                t = (o == 1) ? c : 0;
                r = x + y + t; fc = (r > 255) ? 1 : 0;
                fac = (((x % 16) + (y % 16) + t) > 15) ? 1 : 0;
                sv = sx + sy + t; fov = (sv > 127 || sv < -128) ? 1 : 0;
                r = r % 256; um = 15;
            end
            2, 3: begin
                bw = (o == 3) ? 1 - c : 0;
                r = x - y - bw; fc = (r >= 0) ? 1 : 0;
                fac = (((x % 16) - (y % 16) - bw) >= 0) ? 1 : 0;
                sv = sx - sy - bw; fov = (sv > 127 || sv < -128) ? 1 : 0;
                r = (r + 256) % 256; um = 15;
            end
            4: begin
                t = x + ((((x % 16) > 9) || ac != 0) ? 6 : 0);
                hi = (t > 153 || c != 0) ? 1 : 0;
                r = (t + (hi != 0 ? 96 : 0)) % 256; fc = hi; um = 1;
            end
            5: begin r = x & y;  um = 4; end
            6: begin r = x | y;  um = 4; end
            7: begin r = x ^ y;  um = 4; end
            8: begin r = 255 - x; um = 4; end
            9:  r = ((x * 2) % 256) + x / 128;
            10: r = x / 2 + (x % 2) * 128;
            11: begin r = ((x * 2) % 256) + c; fc = x / 128; um = 1; end
            12: begin r = x / 2 + c * 128; fc = x % 2; um = 1; end
            13: begin r = (x + 1) % 256; um = 4; end
            14: begin r = (x + 255) % 256; um = 4; end
            15: begin r = x; sk = (x == 0) ? 1 : 0; end
            16: begin r = x; sk = (x != 0) ? 1 : 0; end
            17: begin r = (x + 1) % 256; sk = (r == 0) ? 1 : 0; end
            18: begin r = (x + 255) % 256; sk = (r == 0) ? 1 : 0; end
            default: r = 0;
        endcase
        fz = (r == 0) ? 1 : 0;
        fc  = (um % 2 == 1) ? fc : 0;
        fac = ((um / 2) % 2 == 1) ? fac : 0;
        fz  = ((um / 4) % 2 == 1) ? fz : 0;
        fov = ((um / 8) % 2 == 1) ? fov : 0;
        return {r[7:0], fov[0], fz[0], fac[0], fc[0], um[3:0], sk[0]};
    endfunction

    task automatic run_case(input int o, input int x, input int y, input int c,
                            input int ac, input string req);
        logic [16:0] exp_v;
        logic [16:0] got;
        @(posedge clk);
        #1;
        op = o[4:0]; a = x[7:0]; b = y[7:0]; ci = c[0]; aci = ac[0];
        exp_v = model(o, x, y, c, ac);
        @(negedge clk);
        got = {res, ovo, zo, aco, co, upd, skp};
        n_chk++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%02h b=%02h c=%0d ac=%0d actual=%05h expected=%05h",
                     req, o, x, y, c, ac, got, exp_v);
        end
    endtask

    task automatic t_idle;   // R13: undefined code shown at start
        run_case(31, 8'hA5, 8'h5A, 1, 1, "R13");
        for (int o = 19; o < 32; o++) run_case(o, 8'hFF, 8'h01, 1, 1, "R13");
    endtask

    task automatic t_add;    // R1 R3 R4 R5 R6
        run_case(0, 8'h7F, 8'h01, 0, 0, "R3");
        run_case(0, 8'hFF, 8'h01, 0, 0, "R1");
        run_case(0, 8'h0F, 8'h01, 1, 0, "R1");
        run_case(1, 8'hFF, 8'h00, 1, 0, "R4");
        run_case(1, 8'h80, 8'h80, 1, 0, "R3");
        for (int x = 0; x < 256; x += 17)
            for (int y = 3; y < 256; y += 29) begin
                run_case(0, x, y, 1, 0, "R1");
                run_case(1, x, y, (x + y) % 2, 0, "R1");
            end
    endtask

    task automatic t_sub;    // R2 R3 R5
        run_case(2, 8'h00, 8'h01, 0, 0, "R2");
        run_case(2, 8'h80, 8'h01, 0, 0, "R3");
        run_case(2, 8'h10, 8'h01, 0, 0, "R2");
        run_case(3, 8'h05, 8'h05, 0, 0, "R2");
        run_case(3, 8'h05, 8'h05, 1, 0, "R4");
        for (int x = 0; x < 256; x += 19)
            for (int y = 1; y < 256; y += 31) begin
                run_case(2, x, y, 0, 1, "R2");
                run_case(3, x, y, x % 2, 0, "R2");
            end
    endtask

    task automatic t_logic;  // R7 R4 R6
        for (int o = 5; o <= 8; o++) begin
            run_case(o, 8'hF0, 8'h0F, 1, 1, "R7");
            run_case(o, 8'hFF, 8'hFF, 1, 1, "R7");
            run_case(o, 8'h00, 8'h00, 0, 0, "R7");
            run_case(o, 8'h3C, 8'hA5, 1, 0, "R6");
        end
    endtask

    task automatic t_rot;    // R8 R9
        for (int x = 0; x < 256; x += 37) begin
            run_case(9,  x, 0, 1, 1, "R8");
            run_case(10, x, 0, 1, 1, "R8");
            run_case(11, x, 0, 0, 0, "R9");
            run_case(11, x, 0, 1, 0, "R9");
            run_case(12, x, 0, 0, 0, "R9");
            run_case(12, x, 0, 1, 0, "R9");
        end
        run_case(11, 8'h80, 0, 0, 0, "R9");
        run_case(12, 8'h01, 0, 0, 0, "R9");
    endtask

    task automatic t_incdec; // R10
        run_case(13, 8'hFF, 0, 1, 1, "R10");
        run_case(13, 8'h7F, 0, 0, 0, "R10");
        run_case(14, 8'h00, 0, 1, 1, "R10");
        run_case(14, 8'h01, 0, 0, 0, "R10");
        run_case(14, 8'h80, 0, 0, 0, "R10");
    endtask

    task automatic t_daa;    // R11
        run_case(4, 8'h9A, 0, 0, 0, "R11");
        run_case(4, 8'h45, 0, 0, 0, "R11");
        run_case(4, 8'h45, 0, 0, 1, "R11");
        run_case(4, 8'h12, 0, 1, 0, "R11");
        run_case(4, 8'h99, 0, 0, 0, "R11");
        run_case(4, 8'hA0, 0, 0, 0, "R11");
        for (int x = 0; x < 256; x += 13) run_case(4, x, 0, x % 2, (x / 2) % 2, "R11");
    endtask

    task automatic t_skip;   // R12
        run_case(15, 8'h00, 0, 1, 1, "R12");
        run_case(15, 8'h01, 0, 1, 1, "R12");
        run_case(16, 8'h00, 0, 0, 0, "R12");
        run_case(16, 8'h40, 0, 0, 0, "R12");
        run_case(17, 8'hFF, 0, 0, 0, "R12");
        run_case(17, 8'hFE, 0, 0, 0, "R12");
        run_case(18, 8'h01, 0, 0, 0, "R12");
        run_case(18, 8'h00, 0, 0, 0, "R12");
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_add();
        t_sub();
        t_logic();
        t_rot();
        t_incdec();
        t_daa();
        t_skip();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule